// File: doc/BRIEF.md
# 9-bit Symbol Error Applier

This block finishes the correction step for one 512-byte data chunk after a Reed-Solomon decoder has run. The decoder hands over a list of up to four errors, each an index of a 9-bit symbol and a 9-bit error pattern, together with a count and a flag that says the chunk is beyond repair. The block walks the list and, for each entry, reads the two bytes that the symbol straddles from an external byte buffer, flips the pattern into the right 9-bit field and writes both bytes back.

Symbols are packed back to back, nine bits each, so a field almost always spans a byte boundary. The block maps a symbol index to an upper byte position and a bit shift, treats the pair (upper byte, byte below it) as one 16-bit little-endian word, and XORs the pattern in at that shift. At the buffer's top end the upper byte does not exist: only the last byte is rewritten. Entries that point past the buffer, or below its start, are skipped. Syndrome computation and locating the errors are done elsewhere.

Top module: `rs_sym_fixer`

## Requirements
- R1: For symbol index n, let p = 9·n, b = p/8 (integer) and r = p mod 8. When r is 0 the upper byte position is t = b−1 and the shift is s = 7; otherwise t = b and s = r−1. The lower byte position is t−1.
- R2: For an entry with 1 ≤ t ≤ 511, the word W = {byte[t], byte[t−1]} becomes W ^ (pattern << s); byte t−1 is written first and byte t is written on the very next cycle, both through the buffer port.
- R3: For an entry with t = 512 only byte 511 is read and written; it becomes byte[511] ^ ((pattern << s) & 0xFF) and no other address is written for that entry.
- R4: An entry with t > 512, or with index 0 (where t would be −1), causes no write at all.
- R5: Entries are applied from entry (count−1) down to entry 0, where entry k sits at bits [k·IDX_W +: IDX_W] of the index bus and [k·9 +: 9] of the pattern bus; a count above 4 is treated as 4.
- R6: When the uncorrectable flag is high at start, no byte is written, and done and fail are both high in the cycle after the start edge.
- R7: A count of zero with the flag low makes done high, with fail low, in the cycle after the start edge, and no byte is written.
- R8: done is a one-cycle pulse that follows the last write of the list; fail is low with it for a correctable chunk and busy is high from the cycle after start until done.
- R9: After reset done, fail, busy and the write enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin applying the list; accepted only when idle |
| err_count | input | 3 | Number of valid entries (values above 4 act as 4) |
| uncorrectable | input | 1 | Decoder could not repair the chunk |
| err_idx | input | 4·IDX_W | Packed symbol indices, entry k at [k·IDX_W +: IDX_W] |
| err_mask | input | 36 | Packed 9-bit error patterns, entry k at [k·9 +: 9] |
| buf_addr | output | 9 | Byte address into the chunk buffer |
| buf_we | output | 1 | Write strobe for the chunk buffer |
| buf_wdata | output | 8 | Byte to write |
| buf_rdata | input | 8 | Byte read, valid one cycle after buf_addr |
| busy | output | 1 | A list is being applied |
| done | output | 1 | One-cycle end-of-list pulse |
| fail | output | 1 | Chunk reported as uncorrectable; valid with done |

## Verification
The zero-count and uncorrectable replies are due exactly one edge after start, so the bench samples done and fail at the falling edge that follows that edge and nowhere else. A real list finishes a variable number of cycles later (one evaluation cycle per entry plus up to four access cycles), so the bench polls done on falling edges with a bound and only then compares the whole buffer and the recorded order of write addresses with values its own model computed from the index formula. One cycle after done it checks that the pulse has dropped.

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer #(
  parameter int IDX_W     = 10,
  parameter int MAX_ERR   = 4,
  parameter int BUF_BYTES = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2:0]               err_count,
  input  logic                     uncorrectable,
  input  logic [MAX_ERR*IDX_W-1:0] err_idx,
  input  logic [MAX_ERR*9-1:0]     err_mask,
  output logic [8:0]               buf_addr,
  output logic                     buf_we,
  output logic [7:0]               buf_wdata,
  input  logic [7:0]               buf_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     fail
);

  localparam int SYM_W  = 9;
  localparam int ADDR_W = $clog2(BUF_BYTES);
  localparam int PTR_W  = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
  localparam int POS_W  = IDX_W + 4;
  localparam int BYTE_W = POS_W - 3;

  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_RDLO, S_RDHI, S_WRLO, S_WRHI} st_t;

  st_t              st;
  logic [PTR_W-1:0] ptr;
  logic [IDX_W-1:0] idx_q  [MAX_ERR];
  logic [SYM_W-1:0] mask_q [MAX_ERR];
  logic [7:0]       lo_q, hi_new_q;
  logic             done_q, fail_q;

  logic [IDX_W-1:0]  cur_idx;
  logic [SYM_W-1:0]  cur_mask;
  logic [POS_W-1:0]  pos;
  logic [BYTE_W-1:0] byte_i, top_pos;
  logic [2:0]        bit_j, shamt;
  logic              skip, single, last;
  logic [15:0]       flip, new_word;
  logic [7:0]        upper_rd;
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic [2:0]        cnt_eff;

  assign cur_idx  = idx_q[ptr];
  assign cur_mask = mask_q[ptr];
  assign pos      = POS_W'({cur_idx, 3'b000}) + POS_W'(cur_idx);
  assign byte_i   = pos[POS_W-1:3];
  assign bit_j    = pos[2:0];
  assign top_pos  = (bit_j == 3'd0) ? byte_i - BYTE_W'(1) : byte_i;
  assign shamt    = (bit_j == 3'd0) ? 3'd7 : bit_j - 3'd1;
  assign skip     = (cur_idx == '0) || (top_pos > BYTE_W'(BUF_BYTES));
  assign single   = (top_pos == BYTE_W'(BUF_BYTES));
  assign lo_addr  = ADDR_W'(top_pos - BYTE_W'(1));
  assign hi_addr  = top_pos[ADDR_W-1:0];
  assign flip     = {7'b0, cur_mask} << shamt;
  assign upper_rd = single ? 8'h00 : buf_rdata;
  assign new_word = {upper_rd, lo_q} ^ flip;
  assign last     = (ptr == '0);
  assign cnt_eff  = (err_count > 3'(MAX_ERR)) ? 3'(MAX_ERR) : err_count;

  assign buf_addr  = (st == S_RDHI || st == S_WRHI) ? hi_addr : lo_addr;
  assign buf_we    = (st == S_WRLO) || (st == S_WRHI);
  assign buf_wdata = (st == S_WRHI) ? hi_new_q : new_word[7:0];
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      lo_q     <= '0;
      hi_new_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      for (int k = 0; k < MAX_ERR; k++) begin
        idx_q[k]  <= '0;
        mask_q[k] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int k = 0; k < MAX_ERR; k++) begin
            idx_q[k]  <= err_idx[k*IDX_W +: IDX_W];
            mask_q[k] <= err_mask[k*SYM_W +: SYM_W];
          end
          if (uncorrectable) begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
          end else if (cnt_eff == 3'd0) begin
            done_q <= 1'b1;
            fail_q <= 1'b0;
          end else begin
            fail_q <= 1'b0;
            ptr    <= PTR_W'(cnt_eff - 3'd1);
            st     <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (!skip) st <= S_RDLO;
          else if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else ptr <= ptr - PTR_W'(1);
        end
        S_RDLO: st <= S_RDHI;
        S_RDHI: begin
          lo_q <= buf_rdata;
          st   <= S_WRLO;
        end
        S_WRLO: begin
          hi_new_q <= new_word[15:8];
          if (!single) st <= S_WRHI;
          else if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            ptr <= ptr - PTR_W'(1);
            st  <= S_EVAL;
          end
        end
        S_WRHI: begin
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            ptr <= ptr - PTR_W'(1);
            st  <= S_EVAL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_UNCORR_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && uncorrectable) |=> (done && fail && !buf_we)); // R6
  AST_ZERO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !uncorrectable && err_count == 3'd0) |=> (done && !fail && !buf_we)); // R7
  AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRLO && !single) |=> (buf_we && buf_addr == $past(buf_addr) + ADDR_W'(1))); // R2
  AST_TOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRLO && single) |-> (buf_addr == ADDR_W'(BUF_BYTES - 1))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !buf_we); // R9

endmodule

// File: tb/rs_sym_fixer_test.sv
module rs_sym_fixer_test;
  localparam int IDX_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] err_count = '0;
  logic uncorrectable = 1'b0;
  logic [4*IDX_W-1:0] err_idx = '0;
  logic [35:0] err_mask = '0;
  logic [8:0] buf_addr;
  logic buf_we;
  logic [7:0] buf_wdata;
  logic [7:0] buf_rdata;
  logic busy, done, fail;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [512];
  logic [7:0] expm [512];
  int wlog [32];
  int wcnt = 0;
  int elog [32];
  int ecnt;

  always #5 clk = ~clk;

  rs_sym_fixer #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
    .uncorrectable(uncorrectable), .err_idx(err_idx), .err_mask(err_mask),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .busy(busy), .done(done), .fail(fail));

  always @(posedge clk) begin
    buf_rdata <= mem[buf_addr];
    if (buf_we) begin
      mem[buf_addr] <= buf_wdata;
      if (wcnt < 32) wlog[wcnt] <= int'(buf_addr);
      wcnt <= wcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_apply(input int idx, input int msk);
    int p, t, s, w;
    p = idx * 9;
    if ((p & 7) == 0) begin t = (p >> 3) - 1; s = 7; end
    else begin t = p >> 3; s = (p & 7) - 1; end
    if (t < 1 || t > 512) return;
    if (t == 512) begin
      expm[511] = expm[511] ^ 8'((msk << s) & 255);
      elog[ecnt] = 511; ecnt++;
    end else begin
      w = ({24'd0, expm[t], expm[t-1]}) ^ (msk << s);
      expm[t-1] = 8'(w);
      expm[t] = 8'(w >> 8);
      elog[ecnt] = t - 1; elog[ecnt+1] = t; ecnt += 2;
    end
  endfunction

  task automatic run_case(input int cnt, input bit unc, input int idx[4], input int msk[4], input string req);
    int eff, waited, bad;
    @(negedge clk);
    for (int a = 0; a < 512; a++) begin mem[a] = 8'($urandom); expm[a] = mem[a]; end
    wcnt = 0; ecnt = 0;
    eff = (cnt > 4) ? 4 : cnt;
    if (!unc) for (int k = eff - 1; k >= 0; k--) model_apply(idx[k], msk[k]);
    for (int k = 0; k < 4; k++) begin
      err_idx[k*IDX_W +: IDX_W] = IDX_W'(idx[k]);
      err_mask[k*9 +: 9] = 9'(msk[k]);
    end
    err_count = 3'(cnt); uncorrectable = unc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (unc || eff == 0) begin
      check(done === 1'b1, unc ? "R6 done" : "R7 done", int'(done), 1);
      check(fail === unc, unc ? "R6 fail" : "R7 fail", int'(fail), int'(unc));
    end else begin
      check(busy === 1'b1, "R8 busy", int'(busy), 1);
      waited = 0;
      while (done !== 1'b1 && waited < 100) begin @(negedge clk); waited++; end
      check(done === 1'b1, "R8 done", int'(done), 1);
      check(fail === 1'b0, "R8 fail", int'(fail), 0);
    end
    @(negedge clk);
    check(done === 1'b0, "R8 pulse", int'(done), 0);
    bad = 0;
    for (int a = 0; a < 512; a++) if (mem[a] !== expm[a]) bad++;
    check(bad == 0, {req, " buffer"}, bad, 0);
    check(wcnt == ecnt, {req, " R5 write count"}, wcnt, ecnt);
    if (wcnt == ecnt) begin
      bad = 0;
      for (int k = 0; k < ecnt && k < 32; k++) if (wlog[k] != elog[k]) bad++;
      check(bad == 0, {req, " R5 write order"}, bad, 0);
    end
  endtask

  function automatic int pick_idx();
    int r;
    r = int'($urandom % 10);
    case (r)
      0: return 0;
      1: return 456;
      2: return 457 + int'($urandom % 567);
      3: return 455;
      default: return 1 + int'($urandom % 455);
    endcase
  endfunction

  initial begin
    int ix[4];
    int mk[4];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && fail === 1'b0 && busy === 1'b0 && buf_we === 1'b0, "R9 reset", int'({done, fail, busy, buf_we}), 0);

    ix = '{0, 0, 0, 0}; mk = '{0, 0, 0, 0};
    run_case(0, 1'b0, ix, mk, "R7 zero");
    ix = '{5, 9, 40, 0}; mk = '{3, 5, 7, 0};
    run_case(3, 1'b1, ix, mk, "R6 uncorrectable");
    ix = '{1, 0, 0, 0}; mk = '{9'h1FF, 0, 0, 0};
    run_case(1, 1'b0, ix, mk, "R1 R2 idx1");
    ix = '{8, 0, 0, 0}; mk = '{9'h155, 0, 0, 0};
    run_case(1, 1'b0, ix, mk, "R1 R2 idx8");
    ix = '{456, 0, 0, 0}; mk = '{9'h1FF, 0, 0, 0};
    run_case(1, 1'b0, ix, mk, "R3 top");
    ix = '{457, 0, 1023, 0}; mk = '{9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF};
    run_case(4, 1'b0, ix, mk, "R4 ignored");
    ix = '{10, 11, 12, 13}; mk = '{1, 2, 4, 8};
    run_case(4, 1'b0, ix, mk, "R5 order");
    ix = '{20, 30, 40, 50}; mk = '{9'h0AA, 9'h101, 9'h033, 9'h1C0};
    run_case(7, 1'b0, ix, mk, "R5 clamp");

    for (int n = 0; n < 250; n++) begin
      for (int k = 0; k < 4; k++) begin ix[k] = pick_idx(); mk[k] = 1 + int'($urandom % 511); end
      run_case(int'($urandom % 6), ($urandom % 16) == 0, ix, mk, "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule